// File: doc/BRIEF.md
# Mode-Dependent Register Width and Address Former

This block sits between a processor's execute stage and its register file and memory port. It takes the effective data-width mode of the current instruction (short or long) and shapes three things from it: the value written back into a register, the memory address presented to the bus, and the width and contents of a register-to-memory store. In short mode the upper address byte does not come from the operand. It comes from a programmable base-page register, so 16-bit code runs inside a chosen 64 KiB page. In long mode the operand passes through at its full width and the base page plays no part.

The block also keeps one flag per architectural register. The flag records whether that register's upper byte is meaningless because its last write was made in short mode. A verification environment uses these flags to treat those bytes as don't-care. The address, write value and store outputs are combinational. Only the base page and the flags hold state.

Top module: `mode_addr_former`

## Requirements
- R1: After reset the base page reads 00h and every upper-byte-undefined flag reads 0.
- R2: With dataLong=0, memAddr equals {basePage, addrIn[15:0]}. This holds even when addrIn carries a full 24-bit value, for example an address fetched with a long instruction stream: its bits 23:16 are replaced.
- R3: With dataLong=1, memAddr equals addrIn[23:0] and the base page has no effect on it.
- R4: With dataLong=0, regWrValue equals {00h, wrValue[15:0]}, which discards bits 23:16 of a fetched 24-bit immediate.
- R5: With dataLong=1, regWrValue equals wrValue[23:0].
- R6: storeBytes is 2 with dataLong=0 and 3 with dataLong=1. storeOut is {00h, storeIn[15:0]} in short mode and storeIn[23:0] in long mode.
- R7: When baseWe is 1 at a rising clock edge, basePage takes baseIn. Otherwise basePage holds its value.
- R8: When regWe is 1 at a rising edge, the flag upperUndef[regIdx] becomes 1 if dataLong=0 and becomes 0 if dataLong=1. All other flags hold. When regWe is 0, no flag changes, whatever dataLong is.
- R9: memAddr, regWrValue, storeOut and storeBytes follow their inputs in the same cycle, with no register stage between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataLong | input | 1 | Effective data mode: 1 selects long (24-bit), 0 selects short (16-bit) |
| baseWe | input | 1 | Load strobe for the base-page register |
| baseIn | input | 8 | New base-page value |
| regWe | input | 1 | A register write-back happens this cycle |
| regIdx | input | 3 | Index of the register being written |
| wrValue | input | 24 | Raw value headed for the register |
| addrIn | input | 24 | Register or immediate address operand |
| storeIn | input | 24 | Register data for a memory store |
| regWrValue | output | 24 | Width-shaped register write value |
| memAddr | output | 24 | Formed memory address |
| storeOut | output | 24 | Width-shaped store data |
| storeBytes | output | 2 | Store byte count (2 or 3) |
| basePage | output | 8 | Current base-page register |
| upperUndef | output | 8 | Per-register upper-byte-undefined flags |

## Verification
Two kinds of internal state can go wrong here. A corrupted base page shows up on memAddr[23:16] on the first short-mode access after the fault, and the basePage port shows it one edge after the bad load. A flag that is set or cleared wrongly shows on upperUndef right after the offending edge. The bench looks at it there, including after cycles where only dataLong toggles with no write. The combinational shaping paths are checked within a cycle of each input change, in both modes and under input patterns that would expose a wrong base, a missing mask or a swapped byte count.

// File: rtl/mode_addr_pkg.sv
package mode_addr_pkg;
  typedef struct packed {
    logic dataLong;
    logic baseLoad;
    logic regWrite;
  } modeStrobes_t;
endpackage

// File: rtl/mode_addr_ctrl.sv
module mode_addr_ctrl
  import mode_addr_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataLong,
  input  logic             baseWe,
  input  logic             regWe,
  input  logic [IDX_W-1:0] regIdx,
  output modeStrobes_t     strobes,
  output logic [NREG-1:0]  upperUndef
);

  always_comb begin
    strobes.dataLong = dataLong;
    strobes.baseLoad = baseWe;
    strobes.regWrite = regWe;
  end

  // One flag per register: a short write marks the upper byte undefined.
  for (genvar g = 0; g < NREG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) upperUndef[g] <= 1'b0;
      else if (regWe && (regIdx == IDX_W'(g))) upperUndef[g] <= !dataLong;
    end
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !dataLong) |=> upperUndef[$past(regIdx)]);
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && dataLong) |=> !upperUndef[$past(regIdx)]);
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(upperUndef));

endmodule

// File: rtl/mode_addr_dp.sv
module mode_addr_dp
  import mode_addr_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 16,
  localparam int PAGE_W = ADDR_W - SHORT_W,
  localparam int CNT_W  = $clog2(ADDR_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  modeStrobes_t      strobes,
  input  logic [PAGE_W-1:0] baseIn,
  input  logic [ADDR_W-1:0] wrValue,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] storeIn,
  output logic [ADDR_W-1:0] regWrValue,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] storeOut,
  output logic [CNT_W-1:0]  storeBytes,
  output logic [PAGE_W-1:0] basePage
);

  localparam logic [CNT_W-1:0] LongBytes  = CNT_W'(ADDR_W / 8);
  localparam logic [CNT_W-1:0] ShortBytes = CNT_W'(SHORT_W / 8);

  always_ff @(posedge clk) begin
    if (!rstN) basePage <= '0;
    else if (strobes.baseLoad) basePage <= baseIn;
  end

  always_comb begin
    if (strobes.dataLong) begin
      memAddr    = addrIn;
      regWrValue = wrValue;
      storeOut   = storeIn;
      storeBytes = LongBytes;
    end else begin
      memAddr    = {basePage, addrIn[SHORT_W-1:0]};
      regWrValue = {{PAGE_W{1'b0}}, wrValue[SHORT_W-1:0]};
      storeOut   = {{PAGE_W{1'b0}}, storeIn[SHORT_W-1:0]};
      storeBytes = ShortBytes;
    end
  end

  p_base_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.baseLoad |=> $stable(basePage));
  p_base_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.baseLoad |=> basePage == $past(baseIn));

  always_comb begin
    if (rstN) begin
      p_short_upper_r4: assert (strobes.dataLong || regWrValue[ADDR_W-1:SHORT_W] == '0);
      p_width_r6: assert (storeBytes == (strobes.dataLong ? LongBytes : ShortBytes));
    end
  end

endmodule

// File: rtl/mode_addr_former.sv
module mode_addr_former
  import mode_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataLong,
  input  logic        baseWe,
  input  logic [7:0]  baseIn,
  input  logic        regWe,
  input  logic [2:0]  regIdx,
  input  logic [23:0] wrValue,
  input  logic [23:0] addrIn,
  input  logic [23:0] storeIn,
  output logic [23:0] regWrValue,
  output logic [23:0] memAddr,
  output logic [23:0] storeOut,
  output logic [1:0]  storeBytes,
  output logic [7:0]  basePage,
  output logic [7:0]  upperUndef
);

  modeStrobes_t strobes;

  mode_addr_ctrl #(.NREG(8)) uCtrl (
    .clk(clk), .rstN(rstN), .dataLong(dataLong), .baseWe(baseWe),
    .regWe(regWe), .regIdx(regIdx), .strobes(strobes), .upperUndef(upperUndef)
  );

  mode_addr_dp #(.ADDR_W(24), .SHORT_W(16)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .baseIn(baseIn),
    .wrValue(wrValue), .addrIn(addrIn), .storeIn(storeIn),
    .regWrValue(regWrValue), .memAddr(memAddr), .storeOut(storeOut),
    .storeBytes(storeBytes), .basePage(basePage)
  );

endmodule

// File: tb/tb_mode_addr_former.sv
module tb_mode_addr_former;
  logic        clk = 0;
  logic        rstN = 0;
  logic        dataLong = 0, baseWe = 0, regWe = 0;
  logic [7:0]  baseIn = 0;
  logic [2:0]  regIdx = 0;
  logic [23:0] wrValue = 0, addrIn = 0, storeIn = 0;
  logic [23:0] regWrValue, memAddr, storeOut;
  logic [1:0]  storeBytes;
  logic [7:0]  basePage, upperUndef;

  int checks = 0, errors = 0;

  mode_addr_former dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic tReset();
    rstN = 0; tick(); tick(); rstN = 1; @(negedge clk);
    chk("R1 basePage", basePage, 0);
    chk("R1 flags", upperUndef, 0);
  endtask

  task automatic tBaseLoad();
    @(negedge clk); baseIn = 8'hA5; baseWe = 1; tick(); baseWe = 0;
    chk("R7 load", basePage, 8'hA5);
    baseIn = 8'h3C; tick(); tick();
    chk("R7 hold", basePage, 8'hA5);
  endtask

  task automatic tShort();
    dataLong = 0;
    addrIn = 24'h123456; #1 chk("R2 long addr replaced", memAddr, 24'hA53456);
    addrIn = 24'hFF0001; #1 chk("R2 pattern2", memAddr, 24'hA50001);
    wrValue = 24'h123456; #1 chk("R4 imm discard", regWrValue, 24'h003456);
    wrValue = 24'hFFFFFF; #1 chk("R4 all ones", regWrValue, 24'h00FFFF);
    storeIn = 24'hABCDEF; #1 chk("R6 short data", storeOut, 24'h00CDEF);
    chk("R6 short bytes", storeBytes, 2);
    @(negedge clk); baseIn = 8'h07; baseWe = 1; tick(); baseWe = 0;
    addrIn = 24'h00BEEF; #1 chk("R2 new base", memAddr, 24'h07BEEF);
  endtask

  task automatic tLong();
    dataLong = 1;
    addrIn = 24'h123456; #1 chk("R3 pass", memAddr, 24'h123456);
    addrIn = 24'h00FFFF; #1 chk("R3 base ignored", memAddr, 24'h00FFFF);
    wrValue = 24'h89ABCD; #1 chk("R5 full", regWrValue, 24'h89ABCD);
    storeIn = 24'hABCDEF; #1 chk("R6 long data", storeOut, 24'hABCDEF);
    chk("R6 long bytes", storeBytes, 3);
    dataLong = 0; #1 chk("R9 same-cycle mode", memAddr, 24'h07FFFF);
    addrIn = 24'h001234; #1 chk("R9 same-cycle addr", memAddr, 24'h071234);
  endtask

  task automatic tFlags();
    @(negedge clk);
    regWe = 1; dataLong = 0; regIdx = 3; tick();
    chk("R8 short set", upperUndef, 8'h08);
    @(negedge clk); dataLong = 1; tick();
    chk("R8 long clear", upperUndef, 8'h00);
    @(negedge clk); dataLong = 0; regIdx = 0; tick();
    @(negedge clk); regIdx = 7; tick();
    chk("R8 two sets", upperUndef, 8'h81);
    @(negedge clk); regWe = 0; dataLong = 1; regIdx = 0; tick();
    @(negedge clk); dataLong = 0; regIdx = 2; tick();
    chk("R8 no write no change", upperUndef, 8'h81);
    @(negedge clk); regWe = 1; dataLong = 1; regIdx = 7; tick(); regWe = 0;
    chk("R8 others hold", upperUndef, 8'h01);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tBaseLoad();
    tShort();
    tLong();
    tFlags();
    tReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule